// File: doc/BRIEF.md
# Nibble-Serial 8x8 Unsigned Multiplier

This block forms the unsigned 16-bit product of two 8-bit operands with a single 4x4 multiplier, used once in each of four consecutive clock steps. A pulse on the start input captures both operands and clears an accumulator. A controller then walks through the four nibble pairings: low by low, the two cross terms, then high by high. Each 8-bit partial product is zero-extended, shifted left by 0, 4 or 8 bits, and added into the accumulator.

A one-cycle done pulse marks the cycle in which the product output first shows the finished result. The product output is the accumulator itself and keeps its value until the next start. A 3-bit state code shows where the controller is. If start is raised while a computation is running, the controller drops into an error state and freezes the partial sum until a new start arrives.

Top module: `nibble_serial_mult`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, state_code reads 000, done is 0 and product is 0.
- R2: If start is sampled high at clock edge k while the controller is idle or in error, done is 1 after edge k+4 and product then equals op_a times op_b as they were sampled at edge k.
- R3: After an accepted start, state_code shows 001 (first step) for one cycle, then 010 (middle steps) for two cycles, then 011 (last step) for one cycle, then 000 (idle).
- R4: done is high for exactly one cycle per finished computation.
- R5: Changes on op_a and op_b after the start edge have no effect on the product of the run in progress.
- R6: If start is high at an edge while state_code is 001, 010 or 011, the controller enters the error state (state_code 100). No accumulation happens at that edge, so product shows the sum of the steps that already finished.
- R7: In the error state, product and state_code stay unchanged while start is low. A start then begins a new computation that gives a correct product.
- R8: In idle with start low, product keeps the last finished result.
- R9: The extreme operands give exact products: 0 x 0 = 0, 255 x 255 = 65025, 0 x 255 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin a computation; must stay low while one is running |
| op_a | input | 8 | Multiplicand, captured when start is accepted |
| op_b | input | 8 | Multiplier, captured when start is accepted |
| product | output | 16 | Accumulator value; the full product once done has pulsed |
| done | output | 1 | One-cycle pulse when product is complete |
| state_code | output | 3 | Controller state: 000 idle, 001 first step, 010 middle steps, 011 last step, 100 error |

## Verification
The hardest situation to reach is an abort in the middle of a run. The partial sum then has to show exactly the steps that finished, and nothing may accumulate while in the error state. The stimulus gets there by holding start high past the first step, and also by raising it again just before the second middle step. The bench compares the frozen product with partial sums it computes itself, then restarts from the error state. A strided sweep covers every op_a value against a quarter of the op_b values, and the low bits are rotated so that every op_b value is still used. During each run the operands are inverted on the pins to show that they are captured.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_LSB  = 3'b001,
    ST_MID  = 3'b010,
    ST_MSB  = 3'b011,
    ST_ERR  = 3'b100
  } nsm_state_e;

  // Shift code per step: step 0 -> none, steps 1 and 2 -> one nibble, step 3 -> two nibbles
  function automatic logic [1:0] shift_code_for(input logic [1:0] step);
    case (step)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      2'd2:    return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/nsm_nib_mul.sv
module nsm_nib_mul #(
  parameter int NW = 4
) (
  input  logic [NW-1:0]   a,
  input  logic [NW-1:0]   b,
  output logic [2*NW-1:0] p
);
  localparam int PW = 2 * NW;

  always_comb p = PW'(a) * PW'(b);
endmodule

// File: rtl/nsm_pp_shift.sv
module nsm_pp_shift #(
  parameter int NW = 4
) (
  input  logic [2*NW-1:0] pp,
  input  logic [1:0]      code,
  output logic [4*NW-1:0] shifted
);
  localparam int RW = 4 * NW;

  logic [RW-1:0] ext;

  always_comb begin
    ext = RW'(pp);
    case (code)
      2'b00:   shifted = ext;
      2'b01:   shifted = ext << NW;
      2'b10:   shifted = ext << (2 * NW);
      default: shifted = '0;
    endcase
  end
endmodule

// File: rtl/nsm_acc.sv
module nsm_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)      acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + addend;
  end
endmodule

// File: rtl/nsm_ctrl.sv
module nsm_ctrl
  import nsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output nsm_state_e state,
  output logic [1:0] sel,
  output logic [1:0] shf,
  output logic       acc_en,
  output logic       acc_clr,
  output logic       capture,
  output logic       done
);
  logic [1:0] step;
  nsm_state_e nxt;
  logic       last_step;

  always_comb begin
    nxt       = state;
    acc_en    = 1'b0;
    acc_clr   = 1'b0;
    capture   = 1'b0;
    last_step = 1'b0;
    case (state)
      ST_IDLE, ST_ERR: begin
        if (start) begin
          nxt     = ST_LSB;
          acc_clr = 1'b1;
          capture = 1'b1;
        end
      end
      ST_LSB: begin
        if (!start && step == 2'd0) begin
          acc_en = 1'b1;
          nxt    = ST_MID;
        end else begin
          nxt = ST_ERR;
        end
      end
      ST_MID: begin
        if (!start && step == 2'd1) begin
          acc_en = 1'b1;
          nxt    = ST_MID;
        end else if (!start && step == 2'd2) begin
          acc_en = 1'b1;
          nxt    = ST_MSB;
        end else begin
          nxt = ST_ERR;
        end
      end
      ST_MSB: begin
        if (!start && step == 2'd3) begin
          acc_en    = 1'b1;
          last_step = 1'b1;
          nxt       = ST_IDLE;
        end else begin
          nxt = ST_ERR;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    sel = step;
    shf = shift_code_for(step);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= 2'd0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      step  <= acc_en ? step + 2'd1 : 2'd0;
      done  <= last_step;
    end
  end

  // R3: an accepted start leads to the first step
  p_start_to_lsb_r3: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE || state == ST_ERR) && start) |=> state == ST_LSB);
  // R3: the first step moves on to the middle steps
  p_lsb_to_mid_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LSB && !start) |=> state == ST_MID);
  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: done only follows the last step
  p_done_after_msb_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state == ST_MSB));
  // R6: start during a run aborts to the error state
  p_run_abort_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LSB || state == ST_MID || state == ST_MSB) && start) |=> state == ST_ERR);
  // R7: the error state is kept while start is low
  p_err_stay_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERR && !start) |=> state == ST_ERR);
endmodule

// File: rtl/nibble_serial_mult.sv
module nibble_serial_mult
  import nsm_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2*NIB_W-1:0]   op_a,
  input  logic [2*NIB_W-1:0]   op_b,
  output logic [4*NIB_W-1:0]   product,
  output logic                 done,
  output logic [2:0]           state_code
);
  localparam int OP_W = 2 * NIB_W;
  localparam int PP_W = 2 * NIB_W;
  localparam int PR_W = 4 * NIB_W;

  nsm_state_e       state;
  logic [1:0]       sel, shf;
  logic             acc_en, acc_clr, capture;
  logic [OP_W-1:0]  a_q, b_q;
  logic [NIB_W-1:0] a_nib, b_nib;
  logic [PP_W-1:0]  pp;
  logic [PR_W-1:0]  pp_shifted;

  nsm_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .state   (state),
    .sel     (sel),
    .shf     (shf),
    .acc_en  (acc_en),
    .acc_clr (acc_clr),
    .capture (capture),
    .done    (done)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (capture) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  // sel[1] picks the high nibble of a, sel[0] the high nibble of b
  always_comb begin
    a_nib = sel[1] ? a_q[OP_W-1:NIB_W] : a_q[NIB_W-1:0];
    b_nib = sel[0] ? b_q[OP_W-1:NIB_W] : b_q[NIB_W-1:0];
  end

  nsm_nib_mul #(.NW(NIB_W)) u_mul (
    .a (a_nib),
    .b (b_nib),
    .p (pp)
  );

  nsm_pp_shift #(.NW(NIB_W)) u_shift (
    .pp      (pp),
    .code    (shf),
    .shifted (pp_shifted)
  );

  nsm_acc #(.W(PR_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr    (acc_clr),
    .en     (acc_en),
    .addend (pp_shifted),
    .acc    (product)
  );

  always_comb state_code = state;

  // R2: the serial sum matches a direct multiply of the captured operands
  p_product_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> product == PR_W'(a_q) * PR_W'(b_q));
  // R6: nothing accumulates while in the error state
  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERR && !start) |=> $stable(product));
  // R8: an idle block keeps its result
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> $stable(product));
  // R5: captured operands do not move during a run
  p_operands_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MID) |=> $stable(a_q) && $stable(b_q));
endmodule

// File: tb/tb_nibble_serial_mult.sv
`timescale 1ns/1ps
module tb_nibble_serial_mult;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [15:0] product;
  logic        done;
  logic [2:0]  state_code;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nibble_serial_mult dut (
    .clk (clk), .rst (rst), .start (start), .op_a (op_a), .op_b (op_b),
    .product (product), .done (done), .state_code (state_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_mul(input int a, input int b);
    int acc = 0;
    for (int i = 0; i < 8; i++) if ((b >> i) & 1) acc += a << i;
    return acc;
  endfunction

  // start at this negedge; product checked after the fifth following edge
  task automatic run_op(input int a, input int b, input string tag);
    @(negedge clk);
    start = 1'b1; op_a = 8'(a); op_b = 8'(b);
    @(negedge clk);
    start = 1'b0; op_a = ~8'(a); op_b = ~8'(b);
    repeat (4) @(negedge clk);
    check(done && product == 16'(ref_mul(a, b)), tag, int'(product), ref_mul(a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int p0, p1;
    repeat (3) @(negedge clk);
    check(state_code == 3'b000 && !done && product == 0, "R1 during reset", int'(state_code), 0);
    rst = 1'b0;
    @(negedge clk);
    check(state_code == 3'b000 && !done && product == 0, "R1 after reset", int'(product), 0);

    // R3 state sequence and R4 pulse, R8 hold
    @(negedge clk);
    start = 1'b1; op_a = 8'h3C; op_b = 8'hA5;
    @(negedge clk); start = 1'b0;
    check(state_code == 3'b001, "R3 first step", int'(state_code), 1);
    @(negedge clk);
    check(state_code == 3'b010, "R3 middle 1", int'(state_code), 2);
    @(negedge clk);
    check(state_code == 3'b010, "R3 middle 2", int'(state_code), 2);
    @(negedge clk);
    check(state_code == 3'b011, "R3 last step", int'(state_code), 3);
    @(negedge clk);
    check(state_code == 3'b000 && done, "R3 R4 idle with done", int'(done), 1);
    check(product == 16'(ref_mul(8'h3C, 8'hA5)), "R2 product", int'(product), ref_mul(8'h3C, 8'hA5));
    @(negedge clk);
    check(!done, "R4 done drops", int'(done), 0);
    repeat (3) @(negedge clk);
    check(product == 16'(ref_mul(8'h3C, 8'hA5)), "R8 product held", int'(product), ref_mul(8'h3C, 8'hA5));

    // R5 explicit: operands inverted on the pins during the run
    run_op(8'h96, 8'h71, "R5 operands captured");

    // R9 corners
    run_op(0, 0, "R9 zero times zero");
    run_op(255, 255, "R9 max times max");
    run_op(0, 255, "R9 zero times max");

    // R6 abort at the first step: accumulator was cleared at start
    @(negedge clk);
    start = 1'b1; op_a = 8'hAB; op_b = 8'hCD;
    @(negedge clk);
    @(negedge clk); start = 1'b0;
    check(state_code == 3'b100, "R6 abort at first step", int'(state_code), 4);
    check(product == 0, "R6 partial empty", int'(product), 0);

    // R7 restart from error
    run_op(8'hAB, 8'hCD, "R7 restart from error");

    // R6 abort before the second middle step
    @(negedge clk);
    start = 1'b1; op_a = 8'hE7; op_b = 8'h5B;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    p0 = (8'hE7 & 15) * (8'h5B & 15);
    p1 = ((8'hE7 & 15) * (8'h5B >> 4)) << 4;
    check(state_code == 3'b100, "R6 abort in middle", int'(state_code), 4);
    check(product == 16'(p0 + p1), "R6 partial sum", int'(product), p0 + p1);
    repeat (3) @(negedge clk);
    check(state_code == 3'b100 && product == 16'(p0 + p1), "R7 error held", int'(product), p0 + p1);
    run_op(8'hE7, 8'h5B, "R7 restart after middle abort");

    // R2 strided sweep: every a, a quarter of b rotating with a
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 64; k++)
        run_op(a, k * 4 + (a % 4), "R2 sweep");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule